// File: doc/BRIEF.md
# Doorway Direction Detector

This block is a synchronous state machine that watches two beam-break sensors placed one behind the other across a doorway. The sensor on the outer side is called "near" and the one on the inner side "far". The block works out the direction of each passage from the order in which the beams break. An entry is the near beam alone, then a gap with no beam broken, then the far beam alone. An exit is the same sequence in the opposite order.

When a passage completes, the block gives a registered pulse one clock long on `enter_pulse` or on `exit_pulse`. A clear input drops a passage that has only partly happened. The current state number is brought out so that a debug view can follow the machine. Debouncing of the sensors and counting of occupants are done outside this block.

Top module: `doorway_dir_fsm`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the machine goes to idle (`state_dbg` = 0) and both pulse outputs are 0.
- R2: In idle (state 0), near-only with clear low moves to state 1, and far-only with clear low moves to state 4. Any other input, including clear high with either beam, keeps the machine in idle.
- R3: Entry path: state 1 holds on near-only and moves to state 2 when neither beam is broken. State 2 holds when neither beam is broken and moves to state 3 on far-only. In each case clear is low.
- R4: Exit path: state 4 holds on far-only and moves to state 5 when neither beam is broken. State 5 holds when neither beam is broken and moves to state 6 on near-only. In each case clear is low.
- R5: In states 1, 2, 4 and 5, clear high returns the machine to idle at the next edge with no pulse, whatever the beams show.
- R6: In states 1, 2, 4 and 5, with clear low, any beam pattern not named in R3 or R4 (for example both beams broken) returns the machine to idle with no pulse.
- R7: State 3 holds while near is 0 and far is 1, whatever clear shows. On any other pattern it returns to idle, and `enter_pulse` is 1 for exactly the cycle after that edge.
- R8: State 6 holds while near is 1 and far is 0, whatever clear shows. On any other pattern it returns to idle, and `exit_pulse` is 1 for exactly the cycle after that edge.
- R9: The pulse outputs are registered and are 0 after every transition not named in R7 or R8. They are never 1 together.
- R10: `state_dbg` is the 3-bit binary state number: 0 for idle, 1 to 3 for the entry path and 4 to 6 for the exit path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| beam_near | input | 1 | Outer sensor, 1 = beam broken |
| beam_far | input | 1 | Inner sensor, 1 = beam broken |
| clr_pass | input | 1 | Drops a partial passage |
| enter_pulse | output | 1 | One-clock pulse per completed entry |
| exit_pulse | output | 1 | One-clock pulse per completed exit |
| state_dbg | output | 3 | Current state number |

## Verification
The situations hardest to reach from the ports are the last states of each path, 3 and 6. They can be entered only through two earlier states, each with its own input pattern, and clear means something different there than in the other states. The bench resets the block and walks it along the legal path to each of the seven states. From there it applies every one of the eight combinations of near, far and clear for a single edge, and compares the next state and both pulses with values it works out from the requirements.

// File: rtl/pc_pkg.sv
// Package: shared state and input-condition types for the doorway
// direction detector. Assumes a 3-bit state register numbered as below.
package pc_pkg;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 3'd0,
        ST_IN_A    = 3'd1,
        ST_IN_GAP  = 3'd2,
        ST_IN_B    = 3'd3,
        ST_OUT_B   = 3'd4,
        ST_OUT_GAP = 3'd5,
        ST_OUT_A   = 3'd6
    } pc_state_e;

    typedef enum logic [2:0] {
        CND_NEAR  = 3'd0,
        CND_FAR   = 3'd1,
        CND_NONE  = 3'd2,
        CND_BOTH  = 3'd3,
        CND_CLEAR = 3'd4
    } pc_cond_e;
endpackage

// File: rtl/pc_cond_decode.sv
// Module: pc_cond_decode
// Turns the raw sensor and clear levels into one condition code, with
// clear taking priority. It also gives the single-beam flags without
// regard to clear, which the final states of each path need.
// Assumes the inputs are already synchronous and debounced.
module pc_cond_decode
    import pc_pkg::*;
(
    input  logic     near_i,
    input  logic     far_i,
    input  logic     clr_i,
    output pc_cond_e cond_o,
    output logic     near_only_o,
    output logic     far_only_o
);
    // Single-beam patterns without regard to clear
    assign near_only_o = near_i & ~far_i;
    assign far_only_o  = far_i & ~near_i;

    // Priority-encode the condition: clear first, then the beam pattern
    always_comb begin
        if (clr_i)
            cond_o = CND_CLEAR;
        else if (near_only_o)
            cond_o = CND_NEAR;
        else if (far_only_o)
            cond_o = CND_FAR;
        else if (near_i & far_i)
            cond_o = CND_BOTH;
        else
            cond_o = CND_NONE;
    end
endmodule

// File: rtl/pc_next_state.sv
// Module: pc_next_state
// Combinational transition function of the detector. It gives the next
// state and the one-shot pulse requests. Assumes the cond/flag encoding
// of pc_cond_decode. Unused state codes fall back to idle.
module pc_next_state
    import pc_pkg::*;
(
    input  pc_state_e cur_i,
    input  pc_cond_e  cond_i,
    input  logic      near_only_i,
    input  logic      far_only_i,
    output pc_state_e nxt_o,
    output logic      enter_set_o,
    output logic      exit_set_o
);
    // Transition table: hold or advance on the expected pattern, else idle
    always_comb begin
        nxt_o       = ST_IDLE;
        enter_set_o = 1'b0;
        exit_set_o  = 1'b0;
        unique case (cur_i)
            ST_IDLE: begin
                if (cond_i == CND_NEAR)     nxt_o = ST_IN_A;
                else if (cond_i == CND_FAR) nxt_o = ST_OUT_B;
            end
            ST_IN_A: begin
                if (cond_i == CND_NEAR)      nxt_o = ST_IN_A;
                else if (cond_i == CND_NONE) nxt_o = ST_IN_GAP;
            end
            ST_IN_GAP: begin
                if (cond_i == CND_NONE)     nxt_o = ST_IN_GAP;
                else if (cond_i == CND_FAR) nxt_o = ST_IN_B;
            end
            ST_IN_B: begin
                if (far_only_i) nxt_o = ST_IN_B;
                else            enter_set_o = 1'b1;
            end
            ST_OUT_B: begin
                if (cond_i == CND_FAR)       nxt_o = ST_OUT_B;
                else if (cond_i == CND_NONE) nxt_o = ST_OUT_GAP;
            end
            ST_OUT_GAP: begin
                if (cond_i == CND_NONE)      nxt_o = ST_OUT_GAP;
                else if (cond_i == CND_NEAR) nxt_o = ST_OUT_A;
            end
            ST_OUT_A: begin
                if (near_only_i) nxt_o = ST_OUT_A;
                else             exit_set_o = 1'b1;
            end
            default: nxt_o = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/doorway_dir_fsm.sv
// Module: doorway_dir_fsm (top)
// Works out the direction of a doorway passage from two beam sensors and
// gives a registered pulse one clock long for each entry or exit.
// Assumes a synchronous active-low reset and inputs already debounced.
module doorway_dir_fsm
    import pc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                beam_near,
    input  logic                beam_far,
    input  logic                clr_pass,
    output logic                enter_pulse,
    output logic                exit_pulse,
    output logic [STATE_W-1:0]  state_dbg
);
    pc_state_e state_q, state_d;
    pc_cond_e  cond;
    logic      near_only, far_only, enter_d, exit_d;

    pc_cond_decode u_dec (
        .near_i      (beam_near),
        .far_i       (beam_far),
        .clr_i       (clr_pass),
        .cond_o      (cond),
        .near_only_o (near_only),
        .far_only_o  (far_only)
    );

    pc_next_state u_ns (
        .cur_i       (state_q),
        .cond_i      (cond),
        .near_only_i (near_only),
        .far_only_i  (far_only),
        .nxt_o       (state_d),
        .enter_set_o (enter_d),
        .exit_set_o  (exit_d)
    );

    // State and output pulse registers, with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            enter_pulse <= 1'b0;
            exit_pulse  <= 1'b0;
        end else begin
            state_q     <= state_d;
            enter_pulse <= enter_d;
            exit_pulse  <= exit_d;
        end
    end

    assign state_dbg = state_q;

    // R9: the two pulses never appear together
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enter_pulse, exit_pulse}));

    // R7: an entry pulse appears only on the return from state 3 to idle
    p_enter_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        enter_pulse |-> (state_q == ST_IDLE && $past(state_q) == ST_IN_B));

    // R8: an exit pulse appears only on the return from state 6 to idle
    p_exit_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exit_pulse |-> (state_q == ST_IDLE && $past(state_q) == ST_OUT_A));

    // R5: clear in a middle state aborts to idle without a pulse
    p_clear_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pass && (state_q == ST_IN_A || state_q == ST_IN_GAP ||
                      state_q == ST_OUT_B || state_q == ST_OUT_GAP))
        |=> (state_q == ST_IDLE && !enter_pulse && !exit_pulse));

    // R2: a lone near beam in idle starts the entry path
    p_idle_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && beam_near && !beam_far && !clr_pass)
        |=> state_q == ST_IN_A);

    // R7: state 3 holds on a lone far beam with no pulse
    p_in_b_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IN_B && beam_far && !beam_near)
        |=> (state_q == ST_IN_B && !enter_pulse));
endmodule

// File: tb/doorway_dir_fsm_tb_top.sv
`timescale 1ns/1ps
// Bench: takes every state along its legal path, then applies all eight
// input combinations and compares with expected values from the requirements.
module doorway_dir_fsm_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       near = 1'b0, far = 1'b0, clr = 1'b0;
    logic       enter_p, exit_p;
    logic [2:0] st;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    doorway_dir_fsm dut_i (
        .clk(clk), .rst_n(rst_n), .beam_near(near), .beam_far(far),
        .clr_pass(clr), .enter_pulse(enter_p), .exit_pulse(exit_p),
        .state_dbg(st)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive inputs away from the edge, then sample just after the edge
    task automatic step(input bit n, input bit f, input bit c);
        @(negedge clk);
        near = n; far = f; clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1", "state after reset", st, 0);
        chk("R1", "enter after reset", enter_p, 0);
        chk("R1", "exit after reset", exit_p, 0);
        @(negedge clk);
        rst_n = 1'b1; near = 0; far = 0; clr = 0;
    endtask

    // Expected next state and pulses, from R2 to R8
    function automatic int model(input int s, input bit n, input bit f, input bit c,
                                 output bit ep, output bit xp);
        bit cn = n & !f & !c;
        bit cf = f & !n & !c;
        bit cz = !n & !f & !c;
        ep = 0; xp = 0;
        case (s)
            0: return cn ? 1 : (cf ? 4 : 0);
            1: return cn ? 1 : (cz ? 2 : 0);
            2: return cz ? 2 : (cf ? 3 : 0);
            3: begin if (f & !n) return 3; ep = 1; return 0; end
            4: return cf ? 4 : (cz ? 5 : 0);
            5: return cz ? 5 : (cn ? 6 : 0);
            6: begin if (n & !f) return 6; xp = 1; return 0; end
            default: return 0;
        endcase
    endfunction

    // Walk a freshly reset block to state s along its legal path (R3, R4, R10)
    task automatic go_to(input int s);
        if (s >= 1 && s <= 3) begin
            step(1, 0, 0); chk("R3", "path to 1", st, 1);
            if (s >= 2) begin step(0, 0, 0); chk("R3", "path to 2", st, 2); end
            if (s >= 3) begin step(0, 1, 0); chk("R3", "path to 3", st, 3); end
        end else if (s >= 4) begin
            step(0, 1, 0); chk("R4", "path to 4", st, 4);
            if (s >= 5) begin step(0, 0, 0); chk("R4", "path to 5", st, 5); end
            if (s >= 6) begin step(1, 0, 0); chk("R4", "path to 6", st, 6); end
        end
    endtask

    initial begin
        int en_cnt, ex_cnt;
        do_reset();
        // Sweep: every state, every input combination (R2 to R9)
        for (int s = 0; s < 7; s++) begin
            for (int v = 0; v < 8; v++) begin
                bit ep, xp;
                int ns;
                do_reset();
                go_to(s);
                ns = model(s, v[2], v[1], v[0], ep, xp);
                step(v[2], v[1], v[0]);
                chk((s == 3) ? "R7" : (s == 6) ? "R8" : (v[0] ? "R5" : "R6"),
                    $sformatf("next state from %0d input %0d", s, v), st, ns);
                chk((s == 3) ? "R7" : "R9", $sformatf("enter from %0d input %0d", s, v), enter_p, ep);
                chk((s == 6) ? "R8" : "R9", $sformatf("exit from %0d input %0d", s, v), exit_p, xp);
                if (ep || xp) begin
                    step(0, 0, 0);
                    chk("R9", "pulse lasts one cycle", enter_p | exit_p, 0);
                end
            end
        end
        // Reset in the middle of a passage (R1)
        do_reset(); go_to(3);
        near = 0; far = 1; clr = 0;
        do_reset();
        // Full trace: one entry, then one exit (R7, R8, R10)
        en_cnt = 0; ex_cnt = 0;
        step(1,0,0); step(1,0,0); step(0,0,0); step(0,0,0); step(0,1,0);
        chk("R10", "trace at 3", st, 3);
        step(0,1,0); step(0,0,0); en_cnt += enter_p; ex_cnt += exit_p;
        chk("R7", "trace back to idle", st, 0);
        step(0,1,0); en_cnt += enter_p; step(0,0,0); step(1,0,0);
        chk("R10", "trace at 6", st, 6);
        step(0,0,0); en_cnt += enter_p; ex_cnt += exit_p;
        step(0,0,0); en_cnt += enter_p; ex_cnt += exit_p;
        chk("R7", "entry pulse count", en_cnt, 1);
        chk("R8", "exit pulse count", ex_cnt, 1);
        // Clear aborted exit: 0,4,5,0 with no pulse (R5)
        step(0,1,0); step(0,0,0);
        chk("R5", "abort trace at 5", st, 5);
        step(1,0,1);
        chk("R5", "abort trace idle", st, 0);
        chk("R5", "abort no pulse", enter_p | exit_p, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule